// File: doc/BRIEF.md
# Reset Button Hold Duration Counter

This block measures how long an active-low push-button style reset input stays asserted. Firmware can then tell a short tap from a long press, for example to trigger a return to factory settings. The pin is asynchronous to the block clock, so it first passes through a chain of synchronising flops. While the synchronised level is low, a counter advances by one on every clock. With the intended 25 MHz reference clock, one count is 40 ns and one second is 25,000,000 counts.

The counter is `CNT_W` bits wide (29 by default, about 21.4 s of range). It stops at its all-ones value and never wraps. When the pin is released the counter keeps its value, and a later press carries on from that value. Only a register write with bit 31 set returns it to zero. The register is read as a 32-bit word: the count sits in the low `CNT_W` bits and every bit above it reads zero. The read path and the clear are plain control pins. No stream interface is involved, so no valid/ready handshake or back-pressure applies.

Top module: `rst_hold_meter`

## Requirements
- R1: A high level on `rst` at a rising clock edge sets the count to zero and returns the synchroniser to the released (high) state, whatever the other inputs are.
- R2: The pin passes through two synchronising flops. If `btn_n` is first sampled low at edge k, the count first rises at edge k+2. A press in which N edges sample the pin low adds exactly N to the count.
- R3: At the all-ones value 2^`CNT_W`-1 the count stays put while the pin remains low, and does not wrap.
- R4: While the synchronised pin is high and no clear is requested, the count keeps its value.
- R5: A new press without an intervening clear continues counting from the held value.
- R6: A write (`wr_en`=1) with `wr_data` bit 31 = 1 sets the count to zero at that edge.
- R7: A write with `wr_data` bit 31 = 0 leaves the count unchanged, whatever its other bits hold.
- R8: When a clear and an increment fall on the same edge, the clear wins and the count becomes zero. Counting resumes on the following edge if the pin is still low.
- R9: `rd_data` bits `CNT_W`-1:0 carry the count, and all bits from `CNT_W` up to 31 read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Reference clock that paces the count |
| rst | input | 1 | Synchronous active-high block reset |
| btn_n | input | 1 | Asynchronous active-low button input |
| wr_en | input | 1 | Register write strobe |
| wr_data | input | 32 | Write data; bit 31 requests a clear |
| rd_data | output | 32 | Length register: count in the low bits, zeros above |

## Verification
The clear write and the per-cycle increment can land on the same edge. The bench provokes this by holding the pin low until the count is already running, then issuing a clear write with bit 31 set for exactly one cycle. It expects zero right after that edge, then one after the next edge, which shows that the clear won and that counting resumed. Saturation is reached by building the bench with a narrow `CNT_W` and holding the pin well past the limit.

// File: rtl/rst_hold_pkg.sv
package rst_hold_pkg;
  localparam int unsigned REG_W   = 32;
  localparam int unsigned CLR_BIT = 31;
endpackage

// File: rtl/rst_hold_sync.sv
module rst_hold_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst,
  input  logic pin_n,
  output logic held
);
  logic [STAGES-1:0] chain;

  generate
    if (STAGES == 1) begin : g_one
      always_ff @(posedge clk) begin
        if (rst) chain <= 1'b1;
        else     chain <= pin_n;
      end
    end else begin : g_many
      always_ff @(posedge clk) begin
        if (rst) chain <= '1;
        else     chain <= {chain[STAGES-2:0], pin_n};
      end
    end
  endgenerate

  assign held = ~chain[STAGES-1];
endmodule

// File: rtl/rst_hold_count.sv
module rst_hold_count #(
  parameter int unsigned CNT_W = 29
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             held,
  input  logic             clr,
  output logic [CNT_W-1:0] cnt
);
  localparam logic [CNT_W-1:0] TOP = {CNT_W{1'b1}};

  logic at_top;
  assign at_top = (cnt == TOP);

  always_ff @(posedge clk) begin
    if (rst)                  cnt <= '0;
    else if (clr)             cnt <= '0;
    else if (held && !at_top) cnt <= cnt + 1'b1;
  end

  AST_CLEAR_WINS: assert property (@(posedge clk) disable iff (rst)
    clr |=> (cnt == '0)); // R8

  AST_NO_WRAP: assert property (@(posedge clk) disable iff (rst)
    (at_top && !clr) |=> (cnt == TOP)); // R3

  AST_IDLE_HOLD: assert property (@(posedge clk) disable iff (rst)
    (!held && !clr) |=> $stable(cnt)); // R4

  AST_STEP_ONE: assert property (@(posedge clk) disable iff (rst)
    (held && !clr && !at_top) |=> (cnt == $past(cnt) + 1'b1)); // R2
endmodule

// File: rtl/rst_hold_meter.sv
module rst_hold_meter
  import rst_hold_pkg::*;
#(
  parameter int unsigned CNT_W       = 29,
  parameter int unsigned SYNC_STAGES = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             btn_n,
  input  logic             wr_en,
  input  logic [REG_W-1:0] wr_data,
  output logic [REG_W-1:0] rd_data
);
  localparam int unsigned PAD_W = REG_W - CNT_W;

  logic             held;
  logic             clr;
  logic [CNT_W-1:0] cnt;

  assign clr = wr_en & wr_data[CLR_BIT];

  rst_hold_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .pin_n (btn_n),
    .held  (held)
  );

  rst_hold_count #(.CNT_W(CNT_W)) u_count (
    .clk  (clk),
    .rst  (rst),
    .held (held),
    .clr  (clr),
    .cnt  (cnt)
  );

  generate
    if (PAD_W > 0) begin : g_pad
      assign rd_data = {{PAD_W{1'b0}}, cnt};
    end else begin : g_full
      assign rd_data = cnt[REG_W-1:0];
    end
  endgenerate

  AST_RESET_ZERO: assert property (@(posedge clk)
    rst |=> (rd_data == '0)); // R1

  AST_KEEP_ON_PLAIN_WRITE: assert property (@(posedge clk) disable iff (rst)
    (btn_n && $past(btn_n) && $past(btn_n, 2) && !clr) |=> $stable(rd_data)); // R7
endmodule

// File: tb/rst_hold_meter_test.sv
module rst_hold_meter_test;
  localparam int unsigned CW = 8;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        btn_n = 1'b1;
  logic        wr_en = 1'b0;
  logic [31:0] wr_data = '0;
  logic [31:0] rd_data;

  int vectors = 0;
  int errors  = 0;
  bit done    = 1'b0;

  logic [31:0] exp_q[$];
  string       tag_q[$];
  event        chk_ev;

  always #10 clk = ~clk;

  rst_hold_meter #(.CNT_W(CW), .SYNC_STAGES(2)) uut (
    .clk(clk), .rst(rst), .btn_n(btn_n),
    .wr_en(wr_en), .wr_data(wr_data), .rd_data(rd_data)
  );

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic expect_val(input logic [31:0] v, input string tag);
    exp_q.push_back(v);
    tag_q.push_back(tag);
    -> chk_ev;
  endtask

  task automatic write_reg(input logic [31:0] d);
    wr_en = 1'b1; wr_data = d;
    tick(1);
    wr_en = 1'b0; wr_data = '0;
  endtask

  // monitor: pops expected items and compares against the register
  initial begin
    forever begin
      @(chk_ev);
      while (exp_q.size() > 0) begin
        logic [31:0] e;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        vectors++;
        if (rd_data !== e) begin
          errors++;
          $display("FAIL %s: rd_data=%0d expected=%0d", t, rd_data, e);
        end
      end
    end
  end

  // driver
  initial begin
    tick(3);
    rst = 1'b0;
    expect_val(0, "R1 reset state");

    btn_n = 1'b0;
    tick(2);
    expect_val(0, "R2 two-flop latency");
    tick(1);
    expect_val(1, "R2 first count");
    tick(9);
    expect_val(10, "R2 steady counting");
    btn_n = 1'b1;
    tick(5);
    expect_val(12, "R4 held after release");
    tick(20);
    expect_val(12, "R4 still held");

    btn_n = 1'b0;
    tick(5);
    btn_n = 1'b1;
    tick(4);
    expect_val(17, "R5 resume from held value");

    write_reg(32'h7FFF_FFFF);
    expect_val(17, "R7 write without bit 31");
    tick(1);
    expect_val(17, "R7 no late effect");

    write_reg(32'h8000_0000);
    expect_val(0, "R6 clear by bit 31");

    btn_n = 1'b0;
    tick(6);
    expect_val(4, "R8 counting before clash");
    write_reg(32'h8000_0000);
    expect_val(0, "R8 clear wins over increment");
    tick(1);
    expect_val(1, "R8 counting resumes");
    tick(3);
    expect_val(4, "R8 continues");

    tick(300);
    expect_val(32'd255, "R3 saturated, R9 upper bits zero");
    tick(1);
    expect_val(32'd255, "R3 no wrap");
    btn_n = 1'b1;
    tick(4);
    expect_val(32'd255, "R9 full word after release");

    btn_n = 1'b0;
    rst = 1'b1;
    tick(1);
    rst = 1'b0;
    btn_n = 1'b1;
    expect_val(0, "R1 reset mid-press");
    tick(4);
    expect_val(0, "R1 synchroniser released");

    tick(2);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
    $finish;
  end

  initial begin
    #200000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run hung, actual=timeout expected=finish");
      $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
      $finish;
    end
  end
endmodule